// File: doc/BRIEF.md
# Activity-Gated Standby Controller

This block decides, cycle by cycle, whether a neighbouring logic array has to stay awake or may rest. It registers a bus of monitored inputs and compares each captured value with the one from the cycle before. Any bit that differs counts as activity. Activity opens an awake window of programmable length, and further activity inside that window starts it again from the top. When the window runs out with the bus quiet, the controller drops to standby. It then raises a freeze enable so the array's last results stay valid and unchanged.

A separate speed-mode input keeps the array awake for good, so it never pays the wake-up delay. Driving speed mode low, its inactive level, allows standby. On every move from standby to awake, the controller emits a single-cycle wake strobe. Analog power switching is left to the surrounding circuit; this block only produces the decisions.

Top module: `activity_sleep_ctrl`

## Requirements
- R1: Asynchronous reset (rstN low) gives isActive=1, wakePulse=0, holdOutputs=0. With the bus quiet, the first clock edge after release loads the window, and isActive stays 1 for windowLen+1 samples after that edge, then falls with no wake strobe.
- R2: The input is registered before it is compared. In standby, a bus value that differs in any bit from the previous capture raises isActive one edge after the capture edge. The capture edge itself leaves isActive at 0.
- R3: wakePulse is high for exactly one cycle on each standby-to-awake move, in the first awake cycle, and at no other time.
- R4: Activity seen while awake reloads the window. If a second change is captured j edges after the first (1 <= j <= windowLen+1), the awake run lasts j+windowLen+1 samples and produces one wake strobe.
- R5: After the last detected activity with speed mode low, isActive stays 1 for windowLen+1 samples and then goes to 0 until new activity arrives.
- R6: holdOutputs is 1 exactly when isActive is 0.
- R7: speedMode=1 in standby forces isActive=1 at the next edge, with a wake strobe, and needs no bus change.
- R8: While speedMode=1 the block never enters standby. When speedMode returns to 0 after a quiet period longer than the window, standby follows at the next edge.
- R9: Several bits changing in one cycle count as one activity event. A bit that flips and flips back on consecutive cycles counts as two events, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busIn | input | BUS_W | Monitored input bus |
| windowLen | input | CNT_W | Awake window length in cycles beyond the load cycle |
| speedMode | input | 1 | 1 = always awake, 0 = standby allowed |
| isActive | output | 1 | 1 = array awake, 0 = standby |
| wakePulse | output | 1 | One-cycle strobe on each wake |
| holdOutputs | output | 1 | Freeze enable for the array's outputs during standby |

## Verification
The assertions check on every cycle that the wake strobe and the rise of isActive coincide, that the freeze enable is the complement of the awake state, that detected activity or speed mode wakes the block at the next edge, and that standby persists while the bus is quiet. The window arithmetic can only be shown by the bench scenarios: the exact length of each awake run for every window length, retriggers at every offset inside the window, multi-bit and flip-back changes, and the exit from speed mode.

// File: rtl/sleep_ctrl_pkg.sv
`timescale 1ns/1ps
package sleep_ctrl_pkg;
  typedef enum logic {
    MODE_ACTIVE  = 1'b0,
    MODE_STANDBY = 1'b1
  } mode_e;

  // control -> datapath
  typedef struct packed {
    logic loadTimer;
  } ctrl_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic anyChange;
    logic timerZero;
  } dp_status_t;
endpackage

// File: rtl/sleep_ctrl_datapath.sv
`timescale 1ns/1ps
module sleep_ctrl_datapath
  import sleep_ctrl_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] busIn,
  input  logic [CNT_W-1:0] windowLen,
  input  ctrl_strobe_t     strobe,
  output dp_status_t       status
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [BUS_W-1:0] busQ;
  logic [BUS_W-1:0] busPrev;
  logic [BUS_W-1:0] bitDiff;
  logic [CNT_W-1:0] count;

  // capture and one-cycle history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busQ    <= '0;
      busPrev <= '0;
    end else begin
      busQ    <= busIn;
      busPrev <= busQ;
    end
  end

  // per-bit transition flags
  for (genvar i = 0; i < BUS_W; i++) begin : g_diff
    assign bitDiff[i] = busQ[i] ^ busPrev[i];
  end

  // retriggerable down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= CNT_ZERO;
    end else if (strobe.loadTimer) begin
      count <= windowLen;
    end else if (count != CNT_ZERO) begin
      count <= count - CNT_ONE;
    end
  end

  assign status.anyChange = |bitDiff;
  assign status.timerZero = (count == CNT_ZERO);
endmodule

// File: rtl/sleep_ctrl_control.sv
`timescale 1ns/1ps
module sleep_ctrl_control
  import sleep_ctrl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         speedMode,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         isActive,
  output logic         wakePulse,
  output logic         holdOutputs
);
  mode_e mode;
  mode_e modeNext;
  logic  firstCycle;
  logic  loadReq;
  logic  wakeNext;

  always_comb begin
    modeNext = mode;
    loadReq  = 1'b0;
    wakeNext = 1'b0;
    case (mode)
      MODE_ACTIVE: begin
        loadReq = status.anyChange | firstCycle;
        if (!speedMode && status.timerZero && !loadReq) begin
          modeNext = MODE_STANDBY;
        end
      end
      MODE_STANDBY: begin
        if (status.anyChange || speedMode) begin
          modeNext = MODE_ACTIVE;
          loadReq  = 1'b1;
          wakeNext = 1'b1;
        end
      end
      default: modeNext = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode        <= MODE_ACTIVE;
      firstCycle  <= 1'b1;
      wakePulse   <= 1'b0;
      holdOutputs <= 1'b0;
    end else begin
      mode        <= modeNext;
      firstCycle  <= 1'b0;
      wakePulse   <= wakeNext;
      holdOutputs <= (modeNext == MODE_STANDBY);
    end
  end

  assign strobe.loadTimer = loadReq;
  assign isActive         = (mode == MODE_ACTIVE);
endmodule

// File: rtl/activity_sleep_ctrl.sv
`timescale 1ns/1ps
module activity_sleep_ctrl
  import sleep_ctrl_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BUS_W-1:0] busIn,
  input  logic [CNT_W-1:0] windowLen,
  input  logic             speedMode,
  output logic             isActive,
  output logic             wakePulse,
  output logic             holdOutputs
);
  ctrl_strobe_t ctrlStrobe;
  dp_status_t   dpStatus;

  sleep_ctrl_datapath #(
    .BUS_W(BUS_W),
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .busIn    (busIn),
    .windowLen(windowLen),
    .strobe   (ctrlStrobe),
    .status   (dpStatus)
  );

  sleep_ctrl_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .speedMode  (speedMode),
    .status     (dpStatus),
    .strobe     (ctrlStrobe),
    .isActive   (isActive),
    .wakePulse  (wakePulse),
    .holdOutputs(holdOutputs)
  );
endmodule

// File: rtl/sleep_ctrl_checker.sv
`timescale 1ns/1ps
module sleep_ctrl_checker (
  input logic clk,
  input logic rstN,
  input logic speedMode,
  input logic anyChange,
  input logic isActive,
  input logic wakePulse,
  input logic holdOutputs
);
  AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (isActive && !$past(isActive))); // R3
  AST_RISE_HAS_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isActive) |-> wakePulse); // R3
  AST_HOLD_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rstN)
    holdOutputs == !isActive); // R6
  AST_ACTIVITY_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    (!isActive && anyChange) |=> (isActive && wakePulse)); // R2
  AST_QUIET_STAYS_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!isActive && !anyChange && !speedMode) |=> !isActive); // R5
  AST_SPEED_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    (speedMode && !isActive) |=> isActive); // R7
  AST_SPEED_HOLDS_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    (speedMode && isActive) |=> isActive); // R8
endmodule

bind activity_sleep_ctrl sleep_ctrl_checker u_sleepChk (
  .clk        (clk),
  .rstN       (rstN),
  .speedMode  (speedMode),
  .anyChange  (dpStatus.anyChange),
  .isActive   (isActive),
  .wakePulse  (wakePulse),
  .holdOutputs(holdOutputs)
);

// File: tb/tb_activity_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_activity_sleep_ctrl;
  localparam int BUS_W = 8;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [BUS_W-1:0] busIn = '0;
  logic [CNT_W-1:0] windowLen = '0;
  logic             speedMode = 1'b0;
  logic             isActive;
  logic             wakePulse;
  logic             holdOutputs;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  activity_sleep_ctrl #(.BUS_W(BUS_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .busIn(busIn), .windowLen(windowLen),
    .speedMode(speedMode), .isActive(isActive), .wakePulse(wakePulse),
    .holdOutputs(holdOutputs)
  );

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic stepSample();
    @(posedge clk);
    #1;
  endtask

  // one burst from standby: first change before edge 0, optional second change before edge retrig
  task automatic runBurst(input int lenCfg, input int retrig, input int bitSel,
                          input bit allBits, input bit sameBit, input string tag);
    int runCount = 0;
    int wakes = 0;
    int wakeBad = 0;
    int holdErr = 0;
    int expected;
    windowLen = CNT_W'(lenCfg);
    stepSample();
    check(isActive == 1'b0, "R5 standby before burst", int'(isActive), 0);
    for (int n = 0; n < 40; n++) begin
      if (n == 0) begin
        if (allBits) busIn = ~busIn;
        else busIn[bitSel] = ~busIn[bitSel];
      end
      if (retrig > 0 && n == retrig) begin
        if (sameBit) busIn[bitSel] = ~busIn[bitSel];
        else busIn[(bitSel + 1) % BUS_W] = ~busIn[(bitSel + 1) % BUS_W];
      end
      stepSample();
      if (n == 0) check(isActive == 1'b0, "R2 capture edge leaves standby", int'(isActive), 0);
      if (isActive) runCount++;
      if (wakePulse) begin
        wakes++;
        if (n != 1) wakeBad++;
      end
      if (holdOutputs != !isActive) holdErr++;
    end
    expected = retrig + lenCfg + 1;
    check(runCount == expected, tag, runCount, expected);
    check(wakes == 1 && wakeBad == 0, "R3 one wake strobe in first awake cycle", wakes, 1);
    check(holdErr == 0, "R6 hold equals standby", holdErr, 0);
  endtask

  initial begin
    int runCount;
    int wakes;
    int stayBad;
    // reset
    windowLen = CNT_W'(3);
    #9;
    check(isActive == 1'b1, "R1 reset isActive", int'(isActive), 1);
    check(wakePulse == 1'b0, "R1 reset wakePulse", int'(wakePulse), 0);
    check(holdOutputs == 1'b0, "R1 reset holdOutputs", int'(holdOutputs), 0);
    @(negedge clk);
    rstN = 1'b1;
    runCount = 0;
    wakes = 0;
    for (int n = 0; n < 20; n++) begin
      stepSample();
      if (isActive) runCount++;
      if (wakePulse) wakes++;
    end
    check(runCount == 4, "R1 post-reset window", runCount, 4);
    check(wakes == 0, "R1 no wake after reset", wakes, 0);

    // R5 and R4 sweep: every window length, every retrigger offset inside the window
    for (int lenCfg = 0; lenCfg <= 6; lenCfg++) begin
      for (int j = 0; j <= lenCfg + 1; j++) begin
        runBurst(lenCfg, j, (lenCfg + j) % BUS_W, 1'b0, 1'b0,
                 (j == 0) ? "R5 awake run length" : "R4 retriggered run length");
      end
    end

    // R9 multi-bit change is one event; flip-back is two events
    runBurst(4, 0, 0, 1'b1, 1'b0, "R9 all bits at once");
    runBurst(4, 1, 5, 1'b0, 1'b1, "R9 flip and flip back");
    runBurst(15, 0, 2, 1'b0, 1'b0, "R5 largest window");

    // R7 speed mode wakes from standby without bus change
    windowLen = CNT_W'(2);
    repeat (3) stepSample();
    check(isActive == 1'b0, "R7 standby before speed mode", int'(isActive), 0);
    speedMode = 1'b1;
    stepSample();
    check(isActive == 1'b1, "R7 speed mode wakes", int'(isActive), 1);
    check(wakePulse == 1'b1, "R7 wake strobe on speed wake", int'(wakePulse), 1);

    // R8 never sleeps while speed mode is set
    stayBad = 0;
    wakes = 0;
    for (int n = 0; n < 40; n++) begin
      if (n == 10) busIn[3] = ~busIn[3];
      stepSample();
      if (!isActive) stayBad++;
      if (wakePulse) wakes++;
    end
    check(stayBad == 0, "R8 stays awake in speed mode", stayBad, 0);
    check(wakes == 0, "R3 no strobe while awake", wakes, 0);
    speedMode = 1'b0;
    stepSample();
    check(isActive == 1'b0, "R8 standby after speed mode cleared", int'(isActive), 0);
    check(holdOutputs == 1'b1, "R6 hold raised in standby", int'(holdOutputs), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end
endmodule